// File: doc/BRIEF.md
# One-Shot Programmable Down Timer

This block is a single-shot interval timer for a small infrared remote-control controller. Software loads a 9-bit count through a byte-wide write port. The low eight bits go to one address. The ninth bit and the control bits go to a second address. Loading the count does not start the timer. Setting the start bit does. While running, the counter steps down by one on every prescaled tick, one tick per 64 system clocks. When the count hits zero, the counter stops by itself and raises a sticky expiry flag.

The block drives a level output that is high while a non-zero count is being run down. A carrier modulator can use this level to gate its carrier. A separate route-enable bit decides whether that level is passed on to the carrier gate output. If the start bit is cleared during a run, the count freezes where it is and the expiry flag is not raised.

Control word at address 1:
- bit 0: count bit 8
- bit 5: route enable
- bit 6: expiry flag (writing 0 clears it, writing 1 keeps it)
- bit 7: start

Top module: `oneshot_tmr_top`

## Requirements
- R1: After reset, count_o is 0, and running_o, route_en_o, expired_o, tmr_lvl_o and carrier_gate_o are all 0.
- R2: A write to address 0 puts wr_data_i[7:0] into count bits 7..0, and a write to address 1 puts wr_data_i[0] into count bit 8. The new value shows on count_o one cycle later, and neither write starts a run.
- R3: A write to address 1 with bit 7 set starts a run (running_o rises the next cycle). Ticks come every 64 clocks while running, and the first decrement shows on count_o exactly 64 cycles after running_o rises.
- R4: While running, count_o drops by exactly one per tick (borrowing across bit 8) and holds its value between ticks.
- R5: On the tick that brings the count to zero, count_o becomes 0, running_o falls and expired_o rises, all on the same edge.
- R6: expired_o stays at 1 until a write to address 1 with bit 6 at 0. A write to address 1 with bit 6 at 1 leaves it set. A tick that expires in the same cycle as a clearing write wins, so the flag ends up set.
- R7: A write to address 1 with bit 7 at 0 during a run stops it. count_o holds its value and expired_o is not raised.
- R8: Starting with a loaded count of 0 gives no underflow. On the first tick, 64 cycles after the start, expired_o rises, running_o falls and count_o stays 0.
- R9: tmr_lvl_o is 1 exactly when running_o is 1 and count_o is non-zero.
- R10: route_en_o follows bit 5 of the last write to address 1. carrier_gate_o equals tmr_lvl_o when route_en_o is 1 and is 0 otherwise.
- R11: A write that lands in the same cycle as a tick overrides the field it writes. The remaining fields take their post-tick values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: low count byte, 1: control word |
| wr_data_i | input | 8 | Write data |
| count_o | output | 9 | Current counter value |
| running_o | output | 1 | Start bit / run state |
| route_en_o | output | 1 | Route-enable bit |
| expired_o | output | 1 | Sticky expiry flag |
| tmr_lvl_o | output | 1 | Timer level output |
| carrier_gate_o | output | 1 | Timer level gated by route enable |

## Verification
The decrement, hold and expiry properties assume that no register write falls in the tick cycle they judge. The properties therefore leave out write cycles. The stop property also assumes that the stopping write keeps bit 6 at 1, so that a run stop is not confused with a flag clear. The directed stimulus issues every write between ticks and keeps bit 6 at 1 except where it means to clear the flag. The random phase deliberately lets writes collide with ticks so that R11 is exercised, and the cycle-level reference model judges those collisions.

// File: rtl/oneshot_tmr_pkg.sv
package oneshot_tmr_pkg;
    // Control word layout (address 1)
    localparam int unsigned ROUTE_BIT = 5;
    localparam int unsigned FLAG_BIT  = 6;
    localparam int unsigned START_BIT = 7;
    localparam logic        ADDR_LOW  = 1'b0;
    localparam logic        ADDR_CTRL = 1'b1;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int unsigned TICK_DIV = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_q_i,
    input  logic run_d_i,
    output logic tick_o
);
    localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    assign tick_o = run_q_i && (pre_q == PRE_LAST);

    always_comb begin
        pre_d = '0;
        if (run_q_i && run_d_i) begin
            pre_d = tick_o ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import oneshot_tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 9,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              run_q_o,
    output logic              run_d_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              route_o,
    output logic              expired_o,
    output logic              lvl_o,
    output logic              gate_o
);
    localparam int unsigned HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             route;
        logic             exp;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       expire_now;

    always_comb begin
        st_d       = st_q;
        expire_now = 1'b0;
        if (tick_i) begin
            if (st_q.cnt <= CNT_ONE) begin
                st_d.cnt   = '0;
                st_d.run   = 1'b0;
                st_d.exp   = 1'b1;
                expire_now = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_LOW) begin
                st_d.cnt[DATA_W-1:0] = wr_data_i;
            end else begin
                st_d.cnt[CNT_W-1:DATA_W] = wr_data_i[HI_W-1:0];
                st_d.run   = wr_data_i[START_BIT];
                st_d.route = wr_data_i[ROUTE_BIT];
                if (!wr_data_i[FLAG_BIT] && !expire_now) begin
                    st_d.exp = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q_o   = st_q.run;
    assign run_d_o   = st_d.run;
    assign count_o   = st_q.cnt;
    assign route_o   = st_q.route;
    assign expired_o = st_q.exp;
    assign lvl_o     = st_q.run && (st_q.cnt != '0);
    assign gate_o    = st_q.route && lvl_o;
endmodule

// File: rtl/oneshot_tmr_top.sv
module oneshot_tmr_top #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TICK_DIV = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              route_en_o,
    output logic              expired_o,
    output logic              tmr_lvl_o,
    output logic              carrier_gate_o
);
    logic tick_w;
    logic run_d_w;

    tmr_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_q_i (running_o),
        .run_d_i (run_d_w),
        .tick_o  (tick_w)
    );

    tmr_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) core_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_w),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .run_q_o   (running_o),
        .run_d_o   (run_d_w),
        .count_o   (count_o),
        .route_o   (route_en_o),
        .expired_o (expired_o),
        .lvl_o     (tmr_lvl_o),
        .gate_o    (carrier_gate_o)
    );
endmodule

// File: rtl/oneshot_tmr_chk.sv
module oneshot_tmr_chk
    import oneshot_tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TICK_DIV = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              running_o,
    input logic              expired_o,
    input logic              tmr_lvl_o,
    input logic              carrier_gate_o,
    input logic              tick_i
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [31:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !running_o || tick_i) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    wire ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> (gap_q == TICK_DIV - 1)); // R3
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> running_o); // R3
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && !tick_i && !wr_en_i) |=> $stable(count_o)); // R4
    AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i && count_o > ONE) |=> (count_o == $past(count_o) - ONE)); // R4
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i && count_o <= ONE) |=> (!running_o && expired_o && count_o == '0)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expired_o && !(ctrl_wr && !wr_data_i[FLAG_BIT])) |=> expired_o); // R6
    AST_STOP_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && !expired_o && !tick_i && ctrl_wr && !wr_data_i[START_BIT] && wr_data_i[FLAG_BIT])
        |=> (!running_o && !expired_o)); // R7
    AST_LEVEL_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o |-> !tmr_lvl_o); // R9
    AST_GATE_FOLLOWS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        carrier_gate_o |-> tmr_lvl_o); // R10
endmodule

bind oneshot_tmr_top oneshot_tmr_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .TICK_DIV(TICK_DIV)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .count_o        (count_o),
    .running_o      (running_o),
    .expired_o      (expired_o),
    .tmr_lvl_o      (tmr_lvl_o),
    .carrier_gate_o (carrier_gate_o),
    .tick_i         (tick_w)
);

// File: tb/oneshot_tmr_tb.sv
module oneshot_tmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [8:0] count;
    logic       running, route_en, expired, lvl, gate;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    oneshot_tmr_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .count_o(count), .running_o(running),
        .route_en_o(route_en), .expired_o(expired), .tmr_lvl_o(lvl),
        .carrier_gate_o(gate)
    );

    // Behavioural reference model
    int m_cnt = 0, m_pre = 0;
    bit m_run = 0, m_route = 0, m_exp = 0;

    always @(posedge clk) begin
        bit t, ex, n_run, n_exp;
        int n_cnt;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_run = 0; m_route = 0; m_exp = 0;
        end else begin
            t = m_run && (m_pre == 63);
            ex = 0; n_run = m_run; n_exp = m_exp; n_cnt = m_cnt;
            if (t) begin
                if (m_cnt <= 1) begin n_cnt = 0; n_run = 0; n_exp = 1; ex = 1; end
                else n_cnt = m_cnt - 1;
            end
            if (wr_en) begin
                if (!wr_addr) n_cnt = (n_cnt / 256) * 256 + int'(wr_data);
                else begin
                    n_cnt = (n_cnt % 256) + (wr_data[0] ? 256 : 0);
                    n_run = wr_data[7];
                    m_route = wr_data[5];
                    if (!wr_data[6] && !ex) n_exp = 0;
                end
            end
            m_pre = (m_run && n_run) ? (t ? 0 : m_pre + 1) : 0;
            m_cnt = n_cnt; m_run = n_run; m_exp = n_exp;
        end
    end

    task automatic chk(string tag, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp_v, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 count vs model", int'(count), m_cnt);
            chk("R5 running vs model", int'(running), int'(m_run));
            chk("R6 expired vs model", int'(expired), int'(m_exp));
            chk("R9 level vs model", int'(lvl), int'(m_run && m_cnt != 0));
            chk("R10 route vs model", int'(route_en), int'(m_route));
            chk("R10 gate vs model", int'(gate), int'(m_route && m_run && m_cnt != 0));
        end
    end

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        logic [15:0] lfsr;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 running", int'(running), 0);
        chk("R1 route", int'(route_en), 0);
        chk("R1 expired", int'(expired), 0);
        chk("R1 level", int'(lvl), 0);
        chk("R1 gate", int'(gate), 0);

        // R2 load without start
        wr(0, 8'h05);
        chk("R2 low byte load", int'(count), 5);
        wr(1, 8'h40);
        chk("R2 high load", int'(count), 5);
        wait_cyc(100);
        chk("R2 no start", int'(running), 0);
        chk("R2 count held idle", int'(count), 5);

        // R3 start and first tick
        wr(1, 8'hC0);
        chk("R3 running rises", int'(running), 1);
        chk("R9 level high while running", int'(lvl), 1);
        n = 0;
        while (count == 9'd5 && n < 200) begin @(negedge clk); n++; end
        chk("R3 first decrement delay", n, 64);
        chk("R4 single step", int'(count), 4);
        wait_cyc(255);
        chk("R4 last step before zero", int'(count), 1);
        chk("R5 not yet expired", int'(expired), 0);
        wait_cyc(1);
        chk("R5 count zero", int'(count), 0);
        chk("R5 running falls", int'(running), 0);
        chk("R5 expired rises", int'(expired), 1);
        chk("R9 level low after expiry", int'(lvl), 0);

        // R6 sticky flag
        wait_cyc(100);
        chk("R6 flag holds", int'(expired), 1);
        wr(1, 8'h40);
        chk("R6 write one keeps flag", int'(expired), 1);
        wr(1, 8'h00);
        chk("R6 write zero clears flag", int'(expired), 0);

        // R8 zero-load start
        wr(0, 8'h00);
        wr(1, 8'hC0);
        chk("R8 running with zero", int'(running), 1);
        chk("R9 level low on zero count", int'(lvl), 0);
        wait_cyc(63);
        chk("R8 no expiry before tick", int'(expired), 0);
        wait_cyc(1);
        chk("R8 expired on first tick", int'(expired), 1);
        chk("R8 no underflow", int'(count), 0);
        chk("R8 running falls", int'(running), 0);
        wr(1, 8'h00);

        // R7 stop mid-run
        wr(0, 8'h2C);
        wr(1, 8'h41);
        chk("R2 nine-bit load", int'(count), 300);
        wr(1, 8'hC1);
        wait_cyc(200);
        wr(1, 8'h41);
        chk("R7 stopped", int'(running), 0);
        chk("R7 count frozen value", int'(count), 297);
        wait_cyc(200);
        chk("R7 count held", int'(count), 297);
        chk("R7 no flag", int'(expired), 0);

        // R4 borrow across bit 8
        wr(0, 8'h01);
        wr(1, 8'hC1);
        wait_cyc(64);
        chk("R4 257 to 256", int'(count), 256);
        wait_cyc(64);
        chk("R4 borrow to 255", int'(count), 255);
        wr(1, 8'h40);
        chk("R7 stop after borrow", int'(count), 255);

        // R10 route enable
        wr(0, 8'h03);
        wr(1, 8'hE0);
        chk("R10 route set", int'(route_en), 1);
        chk("R10 gate follows level", int'(gate), 1);
        wait_cyc(10);
        wr(1, 8'hC0);
        chk("R10 gate off when unrouted", int'(gate), 0);
        chk("R10 level still high", int'(lvl), 1);
        wr(1, 8'hE0);
        chk("R10 gate back on", int'(gate), 1);
        wait_cyc(250);
        chk("R10 gate low after expiry", int'(gate), 0);
        wr(1, 8'h00);

        // R11 random writes colliding with ticks, judged by the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wait_cyc(int'(lfsr[6:0]));
            wr(lfsr[7], lfsr[15:8] & 8'hE1 | 8'h40);
            if (lfsr[3:0] == 4'h0) wr(1, 8'h00);
        end
        wait_cyc(5);
        finish_run();
    end
endmodule